// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block sits between a CPU with a 16-bit address bus and a cartridge ROM that is larger than the CPU can address at once, plus an 8 KB work RAM. The CPU address space is split into three 16 KB ROM windows and one 16 KB RAM region. The lowest window always shows ROM page 0. The middle and upper windows show pages taken from two writable page registers. For each CPU access the block produces a physical ROM address, or a RAM address with read and write strobes. All of these are registered, so they appear one cycle after the request.

The page registers are mapped onto the last bytes of the address space. That area also belongs to the mirrored work RAM, so a write there updates both the RAM and the register. Page numbers are limited to the pages that exist. The limit comes from a mask computed at elaboration from the `ROM_BYTES` parameter: the ROM size is rounded up to a power of two, then divided by 16 KB, then reduced by one. The ROM must be at least 32 KB and at most 4 MB.

Top module: `rom_bank_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all strobes, address outputs and `ram_wdata` are 0, `slot1_page` is 1, `slot2_page` is 2 and `slot0_reg` is 0.
- R2: A read at 0x0000–0x3FFF gives `rom_rd`=1 one cycle later with `rom_addr` = address bits 13:0 and page bits 0.
- R3: A read at 0x4000–0x7FFF gives `rom_rd`=1 one cycle later with `rom_addr` = {`slot1_page` at request time, address bits 13:0}.
- R4: A read at 0x8000–0xBFFF gives `rom_rd`=1 one cycle later with `rom_addr` = {`slot2_page` at request time, address bits 13:0}.
- R5: Any access at 0xC000–0xFFFF drives `ram_addr` = address bits 12:0 one cycle later. A read raises `ram_rd`. A write raises `ram_we` and drives `ram_wdata`. 0xE000–0xFFFF therefore mirrors 0xC000–0xDFFF.
- R6: A write at 0xFFF8 or above loads the register picked by address bits 3:0. 0xD selects `slot0_reg`, 0xE selects `slot1_page` and 0xF selects `slot2_page`. The new value is visible the following cycle. Writes below 0xFFF8 never change these registers.
- R7: Values written to index 0xE or 0xF are ANDed with the page mask. For the default 192 KB ROM the mask is 0x0F.
- R8: A value written to index 0xD is stored unmasked in `slot0_reg`. Reads of 0x0000–0x3FFF still use page 0.
- R9: Writes at 0x0000–0xBFFF raise no strobe and change no register.
- R10: At most one of `rom_rd`, `ram_rd` and `ram_we` is high in any cycle. A cycle with no request drives all strobes low and all address and write-data outputs to 0. A request with both `cpu_rd` and `cpu_wr` set is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW (18) | Physical ROM byte address |
| ram_rd | output | 1 | Work RAM read strobe |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 13 | Work RAM address |
| ram_wdata | output | 8 | Work RAM write data |
| slot0_reg | output | 8 | Stored value of register index 0xD |
| slot1_page | output | 8 | Page shown at 0x4000–0x7FFF |
| slot2_page | output | 8 | Page shown at 0x8000–0xBFFF |

## Verification
A corrupted page register is visible at the ports at once, on the page outputs. The next read of the affected window then shows wrong upper `rom_addr` bits one cycle after the request. A decode fault appears on the cycle after the access as a wrong strobe or a RAM address that is not mirrored. A masking or index-select fault only appears after a write to the register area, so the stimulus writes values with upper bits set and writes just below 0xFFF8 and at mirror addresses. Each of these writes is followed by a read of the window involved.

// File: rtl/rom_bank_mapper_pkg.sv
package rom_bank_mapper_pkg;
  localparam int PAGE_SHIFT = 14;
  localparam int RAM_AW     = 13;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_SLOT0 = 2'd1,
    REG_SLOT1 = 2'd2,
    REG_SLOT2 = 2'd3
  } map_reg_e;

  typedef enum logic [1:0] {
    RGN_PAGE0 = 2'd0,
    RGN_SLOT1 = 2'd1,
    RGN_SLOT2 = 2'd2,
    RGN_RAM   = 2'd3
  } region_e;

  typedef struct packed {
    region_e  region;
    logic     rom_rd;
    logic     ram_rd;
    logic     ram_we;
    map_reg_e reg_sel;
  } decode_t;

  function automatic int page_bits_for(input int rom_bytes);
    return $clog2(rom_bytes) - PAGE_SHIFT;
  endfunction
endpackage

// File: rtl/rom_bank_mapper_decode.sv
module rom_bank_mapper_decode
  import rom_bank_mapper_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  output decode_t     dec
);
  logic in_reg_area;

  always_comb begin
    dec         = '0;
    dec.region  = region_e'(addr[15:14]);
    in_reg_area = (addr >= 16'hFFF8);
    if (dec.region == RGN_RAM) begin
      dec.ram_we = wr;
      dec.ram_rd = rd && !wr;
    end else begin
      dec.rom_rd = rd && !wr;
    end
    if (wr && in_reg_area) begin
      unique case (addr[3:0])
        4'hD:    dec.reg_sel = REG_SLOT0;
        4'hE:    dec.reg_sel = REG_SLOT1;
        4'hF:    dec.reg_sel = REG_SLOT2;
        default: dec.reg_sel = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rom_bank_mapper_regs.sv
module rom_bank_mapper_regs
  import rom_bank_mapper_pkg::*;
#(
  parameter logic [7:0] PAGE_MASK = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  map_reg_e        sel,
  input  logic [7:0]      wdata,
  output logic [2:0][7:0] regs
);
  for (genvar i = 0; i < 3; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = 8'(i);
    localparam logic [7:0] KEEP    = (i == 0) ? 8'hFF : PAGE_MASK;
    logic hit;
    assign hit = (sel == map_reg_e'(i + 1));
    always_ff @(posedge clk) begin
      if (rst)      regs[i] <= RST_VAL;
      else if (hit) regs[i] <= wdata & KEEP;
    end
  end
endmodule

// File: rtl/rom_bank_mapper_phys.sv
module rom_bank_mapper_phys
  import rom_bank_mapper_pkg::*;
#(
  parameter int PB = 4
) (
  input  region_e              region,
  input  logic [13:0]          offset,
  input  logic [7:0]           page1,
  input  logic [7:0]           page2,
  output logic [PB+13:0]       phys
);
  logic [PB-1:0] page;

  always_comb begin
    unique case (region)
      RGN_SLOT1: page = page1[PB-1:0];
      RGN_SLOT2: page = page2[PB-1:0];
      default:   page = '0;
    endcase
    phys = {page, offset};
  end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rom_bank_mapper_pkg::*;
#(
  parameter int ROM_BYTES = 196608
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [15:0]                            cpu_addr,
  input  logic                                   cpu_rd,
  input  logic                                   cpu_wr,
  input  logic [7:0]                             cpu_wdata,
  output logic                                   rom_rd,
  output logic [page_bits_for(ROM_BYTES)+13:0]   rom_addr,
  output logic                                   ram_rd,
  output logic                                   ram_we,
  output logic [12:0]                            ram_addr,
  output logic [7:0]                             ram_wdata,
  output logic [7:0]                             slot0_reg,
  output logic [7:0]                             slot1_page,
  output logic [7:0]                             slot2_page
);
  localparam int         PB        = page_bits_for(ROM_BYTES);
  localparam int         ROM_AW    = PB + PAGE_SHIFT;
  localparam logic [7:0] PAGE_MASK = 8'((1 << PB) - 1);

  decode_t            dec;
  logic [2:0][7:0]    regs;
  logic [ROM_AW-1:0]  phys;

  rom_bank_mapper_decode u_decode (
    .addr (cpu_addr),
    .rd   (cpu_rd),
    .wr   (cpu_wr),
    .dec  (dec)
  );

  rom_bank_mapper_regs #(.PAGE_MASK(PAGE_MASK)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .sel   (dec.reg_sel),
    .wdata (cpu_wdata),
    .regs  (regs)
  );

  rom_bank_mapper_phys #(.PB(PB)) u_phys (
    .region (dec.region),
    .offset (cpu_addr[13:0]),
    .page1  (regs[1]),
    .page2  (regs[2]),
    .phys   (phys)
  );

  assign slot0_reg  = regs[0];
  assign slot1_page = regs[1];
  assign slot2_page = regs[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd    <= 1'b0;
      rom_addr  <= '0;
      ram_rd    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      rom_rd    <= dec.rom_rd;
      rom_addr  <= dec.rom_rd ? phys : '0;
      ram_rd    <= dec.ram_rd;
      ram_we    <= dec.ram_we;
      ram_addr  <= (dec.ram_rd || dec.ram_we) ? cpu_addr[RAM_AW-1:0] : '0;
      ram_wdata <= dec.ram_we ? cpu_wdata : '0;
    end
  end
endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk #(
  parameter int         PB        = 4,
  parameter logic [7:0] PAGE_MASK = 8'h0F
) (
  input logic           clk,
  input logic           rst,
  input logic [15:0]    cpu_addr,
  input logic           cpu_rd,
  input logic           cpu_wr,
  input logic           rom_rd,
  input logic [PB+13:0] rom_addr,
  input logic           ram_rd,
  input logic           ram_we,
  input logic [12:0]    ram_addr,
  input logic [7:0]     slot1_page,
  input logic [7:0]     slot2_page
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_rd, ram_rd, ram_we})); // R10

  AST_PAGE0_FIXED: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr < 16'h4000)
    |=> (rom_rd && rom_addr[PB+13:14] == '0)); // R2

  AST_SLOT1_PAGE: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b01)
    |=> (rom_rd && rom_addr[PB+13:14] == $past(slot1_page[PB-1:0]))); // R3

  AST_SLOT2_PAGE: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b10)
    |=> (rom_rd && rom_addr[PB+13:14] == $past(slot2_page[PB-1:0]))); // R4

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:14] == 2'b11)
    |=> (ram_we && ram_addr == $past(cpu_addr[12:0]))); // R5

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == 16'hFFFE) |=> $stable(slot1_page)); // R6

  AST_PAGE_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((slot1_page & ~PAGE_MASK) == 8'h00) && ((slot2_page & ~PAGE_MASK) == 8'h00)); // R7

  AST_ROM_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr < 16'hC000) |=> (!rom_rd && !ram_we && !ram_rd)); // R9
endmodule

bind rom_bank_mapper rom_bank_mapper_chk #(.PB(PB), .PAGE_MASK(PAGE_MASK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .rom_rd     (rom_rd),
  .rom_addr   (rom_addr),
  .ram_rd     (ram_rd),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .slot1_page (slot1_page),
  .slot2_page (slot2_page)
);

// File: tb/rom_bank_mapper_bench.sv
`timescale 1ns/1ps
module rom_bank_mapper_bench;
  localparam int ROM_BYTES = 196608;
  localparam int ROM_AW    = 18;

  logic              clk = 1'b0;
  logic              rst;
  logic [15:0]       cpu_addr;
  logic              cpu_rd, cpu_wr;
  logic [7:0]        cpu_wdata;
  logic              rom_rd, ram_rd, ram_we;
  logic [ROM_AW-1:0] rom_addr;
  logic [12:0]       ram_addr;
  logic [7:0]        ram_wdata, slot0_reg, slot1_page, slot2_page;

  always #2.5 clk = ~clk;

  rom_bank_mapper #(.ROM_BYTES(ROM_BYTES)) u_rom_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .rom_rd(rom_rd), .rom_addr(rom_addr), .ram_rd(ram_rd),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .slot0_reg(slot0_reg), .slot1_page(slot1_page), .slot2_page(slot2_page)
  );

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit chk_on = 0;
  int mask;

  // reference model state
  int m_p0, m_p1, m_p2;
  int e_rom_rd, e_rom_addr, e_ram_rd, e_ram_we, e_ram_addr, e_ram_wdata;

  initial begin
    int sz = 16384;
    while (sz < ROM_BYTES) sz = sz * 2;
    mask = sz / 16384 - 1;
  end

  always @(posedge clk) begin
    int a;
    a = int'(cpu_addr);
    if (rst) begin
      m_p0 = 0; m_p1 = 1; m_p2 = 2;
      e_rom_rd = 0; e_rom_addr = 0; e_ram_rd = 0; e_ram_we = 0;
      e_ram_addr = 0; e_ram_wdata = 0;
    end else begin
      e_rom_rd = (cpu_rd && !cpu_wr && a < 'hC000) ? 1 : 0;
      e_rom_addr = 0;
      if (e_rom_rd == 1) begin
        if (a < 'h4000)      e_rom_addr = a % 16384;
        else if (a < 'h8000) e_rom_addr = m_p1 * 16384 + a % 16384;
        else                 e_rom_addr = m_p2 * 16384 + a % 16384;
      end
      e_ram_we = (cpu_wr && a >= 'hC000) ? 1 : 0;
      e_ram_rd = (cpu_rd && !cpu_wr && a >= 'hC000) ? 1 : 0;
      e_ram_addr = (e_ram_we == 1 || e_ram_rd == 1) ? a % 8192 : 0;
      e_ram_wdata = (e_ram_we == 1) ? int'(cpu_wdata) : 0;
      if (cpu_wr && a >= 'hFFF8) begin
        if (a % 16 == 13) m_p0 = int'(cpu_wdata);
        if (a % 16 == 14) m_p1 = int'(cpu_wdata) & mask;
        if (a % 16 == 15) m_p2 = int'(cpu_wdata) & mask;
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("rom_rd", int'(rom_rd), e_rom_rd);
      cmp("rom_addr", int'(rom_addr), e_rom_addr);
      cmp("ram_rd", int'(ram_rd), e_ram_rd);
      cmp("ram_we", int'(ram_we), e_ram_we);
      cmp("ram_addr", int'(ram_addr), e_ram_addr);
      cmp("ram_wdata", int'(ram_wdata), e_ram_wdata);
      cmp("slot0_reg", int'(slot0_reg), m_p0);
      cmp("slot1_page", int'(slot1_page), m_p1);
      cmp("slot2_page", int'(slot2_page), m_p2);
    end
  end

  task automatic drive(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    #0.5;
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
  endtask
  task automatic rd(input logic [15:0] a); drive(a, 1'b1, 1'b0, 8'h00); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d); drive(a, 1'b0, 1'b1, d); endtask
  task automatic idle(); drive(16'h0000, 1'b0, 1'b0, 8'h00); endtask

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    @(posedge clk); @(negedge clk);
    chk_on = 1;
    cur_req = "R1";
    idle(); idle();
    @(negedge clk); #0.5 rst = 1'b0;
    idle(); idle();
    cur_req = "R2";
    rd(16'h0000); rd(16'h1234); rd(16'h3FFF);
    cur_req = "R3";
    rd(16'h4000); rd(16'h5ABC); rd(16'h7FFF);
    cur_req = "R4";
    rd(16'h8000); rd(16'hBFFF);
    cur_req = "R6";
    wr(16'hFFFE, 8'h05); rd(16'h4001);
    cur_req = "R7";
    wr(16'hFFFF, 8'h3C); rd(16'h9000);
    wr(16'hFFFE, 8'hFF); rd(16'h7000);
    cur_req = "R8";
    wr(16'hFFFD, 8'hA7); rd(16'h0010); rd(16'h3FF0);
    cur_req = "R9";
    wr(16'h2000, 8'h55); wr(16'h6000, 8'h01); wr(16'hA000, 8'h02); rd(16'h4444);
    cur_req = "R5";
    wr(16'hC000, 8'h11); wr(16'hDFFF, 8'h22); wr(16'hE123, 8'h33); rd(16'hF000); rd(16'hC555);
    cur_req = "R6";
    wr(16'hFFF7, 8'h09); wr(16'hFFEE, 8'h09); wr(16'hDFFE, 8'h09); wr(16'hFFF8, 8'h09);
    rd(16'h4000); rd(16'h8000);
    cur_req = "R10";
    idle(); drive(16'hC010, 1'b1, 1'b1, 8'h44); drive(16'h4010, 1'b1, 1'b1, 8'h44); idle();
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (i % 5 == 0) a = 16'hFFF8 | 16'($urandom % 8);
      drive(a, 1'($urandom), 1'($urandom % 3 == 0), 8'($urandom));
    end
    idle(); idle();
    cur_req = "R1";
    @(negedge clk); #0.5 rst = 1'b1;
    idle(); idle();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule